// File: doc/BRIEF.md
# Lookup-Table Masked Compare Trigger Term

This block decides, every clock, whether a 32-bit logic-analyzer sample matches a programmed pattern in which only some bit positions are compared. It holds no target register and no mask register. The sample is cut into eight 4-bit nibbles. Each nibble indexes its own 16-entry, one-bit table. Each table already holds the compare result for every value that nibble can take. The term fires when every nibble's table reports a match. The tables hold 128 bits in total and are loaded over one serial shift chain. This makes reprogramming cheap in wiring, and the compare itself is only a table read plus an 8-input AND.

The host prepares four 32-bit configuration words. Entry `i` of a nibble's table is 1 exactly when `((i ^ target_nibble) & mask_nibble) == 0`. A bit cleared in the mask therefore always counts as a match. The host then shifts the words in, one bit per clock while the shift enable is high. The registered hit output feeds downstream trigger sequencing.

Top module: `trig_term_lut`

## Requirements
- R1: `hit` is registered. The value on `hit` after a rising edge is the match result for the `sample` and table contents present before that edge, so a new sample shows on `hit` exactly one clock later.
- R2: While `rst` is high at a rising edge, `hit` becomes 0 and all 128 table bits are cleared. With cleared tables, `hit` stays 0 for every sample until the tables are loaded.
- R3: Table entry `i` of nibble `n` (sample bits `4n+3:4n`) is 1 exactly when `((i ^ target[4n+3:4n]) & mask[4n+3:4n]) == 0`. With an all-zero mask, every sample produces a hit.
- R4: With a full mask (all 32 bits set), `hit` is 1 only when `sample` equals the target, and any single flipped bit gives 0.
- R5: With a partial mask, `hit` equals `((sample ^ target) & mask) == 0`. Unmasked sample bits have no effect.
- R6: Each rising edge with `shift_en` high moves the chain by one bit. `shift_in` enters table 0 at entry 0, and each entry passes to the next one up. Entry 15 of table n passes to entry 0 of table n+1. Configuration words are shifted MSB first, in this order: nibbles 7:6, then 5:4, then 3:2, then 1:0. In each word, bits 15:0 hold the lower nibble's table and bits 31:16 hold the upper nibble's table, with bit `i` holding entry `i`.
- R7: With `shift_en` low, the table contents hold and `shift_in` is ignored.
- R8: `hit` is 1 only when all eight nibble tables return 1. A mismatch in any single nibble forces 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Advance the table chain by one bit |
| shift_in | input | 1 | Serial configuration bit entering the chain |
| sample | input | 32 | Logic-analyzer sample to compare |
| hit | output | 1 | Registered match result |

## Verification
The compare result is due one clock after the sample is applied. The bench drives each sample on a falling edge, waits for the next rising edge, and reads `hit` one time unit later. It also reads `hit` just before that edge to confirm the old value still holds. Each configuration bit lands on the rising edge where `shift_en` is high. The bench therefore checks only after all 128 shifts are done and `shift_en` has been dropped on a falling edge. After reset, `hit` is checked against 0 on the first sampled edge, and again over a sweep of samples before any load.

// File: rtl/trig_term_pkg.sv
package trig_term_pkg;
  parameter int unsigned TT_NIBBLE_W = 4;
  parameter int unsigned TT_NIBBLES  = 8;
endpackage

// File: rtl/lut_slice_table.sv
module lut_slice_table #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             chain_in,
  output logic [DEPTH-1:0] tbl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q <= '0;
    end else if (shift_en) begin
      tbl_q <= {tbl_q[DEPTH-2:0], chain_in};
    end
  end
endmodule

// File: rtl/slice_and_reg.sv
module slice_and_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] slice_ok,
  output logic         hit
);
  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= &slice_ok;
  end
endmodule

// File: rtl/trig_term_lut.sv
module trig_term_lut
  import trig_term_pkg::*;
#(
  parameter int unsigned NIBBLE_W = TT_NIBBLE_W,
  parameter int unsigned NIBBLES  = TT_NIBBLES,
  localparam int unsigned SAMPLE_W  = NIBBLE_W * NIBBLES,
  localparam int unsigned DEPTH     = 1 << NIBBLE_W,
  localparam int unsigned CHAIN_LEN = DEPTH * NIBBLES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                shift_in,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                hit
);
  logic [CHAIN_LEN-1:0] chain_flat;
  logic [NIBBLES-1:0]   slice_ok;

  for (genvar s = 0; s < NIBBLES; s++) begin : g_nib
    logic             feed;
    logic [DEPTH-1:0] row;
    if (s == 0) begin : g_head
      assign feed = shift_in;
    end else begin : g_link
      assign feed = chain_flat[s*DEPTH-1];
    end
    lut_slice_table #(.ADDR_W(NIBBLE_W)) u_tbl (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .chain_in (feed),
      .tbl_q    (row)
    );
    assign chain_flat[s*DEPTH +: DEPTH] = row;
    assign slice_ok[s] = row[sample[s*NIBBLE_W +: NIBBLE_W]];
  end

  slice_and_reg #(.N(NIBBLES)) u_and (
    .clk      (clk),
    .rst      (rst),
    .slice_ok (slice_ok),
    .hit      (hit)
  );
endmodule

// File: rtl/trig_term_lut_chk.sv
module trig_term_lut_chk #(
  parameter int unsigned NIBBLES   = 8,
  parameter int unsigned CHAIN_LEN = 128
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 shift_en,
  input logic                 shift_in,
  input logic [NIBBLES-1:0]   slice_ok,
  input logic [CHAIN_LEN-1:0] chain_flat,
  input logic                 hit
);
  // R2
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!hit && chain_flat == '0));
  // R1
  hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hit == &$past(slice_ok)));
  // R8
  any_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (slice_ok != {NIBBLES{1'b1}}) |=> !hit);
  // R6
  shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (chain_flat[0] == $past(shift_in)));
  // R6
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (chain_flat[CHAIN_LEN-1:1] == $past(chain_flat[CHAIN_LEN-2:0])));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain_flat));
endmodule

bind trig_term_lut trig_term_lut_chk #(.NIBBLES(NIBBLES), .CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .shift_en   (shift_en),
  .shift_in   (shift_in),
  .slice_ok   (slice_ok),
  .chain_flat (chain_flat),
  .hit        (hit)
);

// File: tb/trig_term_lut_tb.sv
`timescale 1ns/1ps
module trig_term_lut_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shift_en = 1'b0;
  logic        shift_in = 1'b0;
  logic [31:0] sample = '0;
  logic        hit;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  trig_term_lut u_dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .shift_in(shift_in),
    .sample(sample), .hit(hit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s sample=%h actual=%b expected=%b", req, sample, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] x = v;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // word k (0..3) covers nibbles 2*(3-k)+1 : 2*(3-k)
  function automatic logic [31:0] cfg_word(input int k, input logic [31:0] t, input logic [31:0] m);
    logic [31:0] w = '0;
    int lo = 2 * (3 - k);
    for (int i = 0; i < 16; i++) begin
      w[i]      = (((i[3:0] ^ t[4*lo +: 4]) & m[4*lo +: 4]) == 4'd0);
      w[16 + i] = (((i[3:0] ^ t[4*(lo+1) +: 4]) & m[4*(lo+1) +: 4]) == 4'd0);
    end
    return w;
  endfunction

  task automatic load(input logic [31:0] t, input logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w = cfg_word(k, t, m);
      for (int b = 31; b >= 0; b--) begin
        @(negedge clk); shift_en = 1'b1; shift_in = w[b];
      end
    end
    @(negedge clk); shift_en = 1'b0; shift_in = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] s, input logic [31:0] t, input logic [31:0] m);
    @(negedge clk); sample = s;
    @(posedge clk); #1;
    check(req, hit, ((s ^ t) & m) == 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] t, m, s;
    repeat (3) @(negedge clk);
    check("R2", hit, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1; check("R2", hit, 1'b0);
    // R2: cleared tables give no hit for any sample
    for (int i = 0; i < 20; i++) begin
      rng = nxt(rng);
      @(negedge clk); sample = rng;
      @(posedge clk); #1; check("R2", hit, 1'b0);
    end

    // R3: all-zero mask hits for any sample
    t = 32'hDEAD_BEEF; m = 32'h0;
    load(t, m);
    for (int i = 0; i < 40; i++) begin rng = nxt(rng); probe("R3", rng, t, m); end

    // R4/R8/R6: full mask, distinct per-nibble target shows ordering
    t = 32'hA5C3_1E7F; m = 32'hFFFF_FFFF;
    load(t, m);
    probe("R4", t, t, m);
    for (int b = 0; b < 32; b++) probe("R8", t ^ (32'd1 << b), t, m);
    probe("R6", {t[15:0], t[31:16]}, t, m);

    // R3: nibble sweep, every table entry against its formula
    t = 32'h3C96_0F5A; m = 32'h5AF0_3C6E;
    load(t, m);
    for (int n = 0; n < 8; n++)
      for (int v = 0; v < 16; v++) begin
        s = t; s[4*n +: 4] = v[3:0];
        probe("R3", s, t, m);
      end

    // R1: new sample appears only after the next edge
    probe("R1", t, t, m);
    @(negedge clk); sample = t ^ m;
    #3; check("R1", hit, 1'b1);
    @(posedge clk); #1; check("R1", hit, 1'b0);

    // R7: toggling shift_in with shift_en low changes nothing
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); shift_in = i[0]; sample = t;
      @(posedge clk); #1; check("R7", hit, 1'b1);
    end
    @(negedge clk); shift_in = 1'b0;

    // R5: several partial masks with random samples
    for (int r = 0; r < 6; r++) begin
      rng = nxt(rng); t = rng; rng = nxt(rng); m = rng;
      load(t, m);
      for (int i = 0; i < 60; i++) begin
        rng = nxt(rng);
        s = (i % 2 == 0) ? (t ^ (rng & ~m)) : rng;
        probe("R5", s, t, m);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule